// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. It takes characters from a transmit queue through a valid/ready handshake. A separate baud generator supplies a single-cycle tick once per bit period, and every bit boundary on the line lines up with one of these ticks. A frame has a low start bit, then 5 to 8 data bits sent least-significant bit first, then an optional even or odd parity bit, then one or two high stop bits.

The frame format comes from configuration inputs. The block captures it when it accepts a character, so the format can change at run time without corrupting a frame that is already on the line. Two enable inputs gate the acceptance of new characters. If either enable is cleared while a frame is going out, that frame still runs through its last stop bit before the block goes idle.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line output is 1, busy is 0, and the line stays at 1 whenever no frame is being sent.
- R2: After a character is accepted, the line goes to 0 (start bit) on the first tick. It stays at 0 until the next tick.
- R3: The data bits follow the start bit, least-significant bit first. Their count is cfg_len_i + 5 (code 0 gives 5 bits, code 3 gives 8). Input data bits above that count are never sent.
- R4: When cfg_par_en_i is 1, one parity bit follows the data bits. With cfg_par_odd_i = 0 it is the XOR of the sent data bits (even parity). With cfg_par_odd_i = 1 it is the inverse of that XOR (odd parity). When cfg_par_en_i is 0, no parity bit is sent.
- R5: The frame ends with stop bits at 1: one stop bit when cfg_two_stop_i is 0, two when it is 1.
- R6: Each bit holds for exactly one tick interval. The line changes only in the cycle after a tick.
- R7: in_ready_o is 1 only when the block is idle and both en_i and tx_en_i are 1. A character is accepted on a cycle with in_valid_i and in_ready_o both 1. The next character is accepted only after the last stop bit's interval has ended.
- R8: busy_o is 1 from the start bit through the end of the final stop bit, and 0 otherwise.
- R9: Clearing en_i or tx_en_i during a frame does not shorten it. While either enable is 0, a pending valid character is not accepted, and the line stays at 1.
- R10: The format is captured at acceptance. Configuration changes during a frame take effect only from the next character.
- R11: Right after reset, with both enables at 1, a valid character is accepted without any further setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| tx_en_i | input | 1 | Transmit enable |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| cfg_len_i | input | 2 | Data length code, bits = code + 5 |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop_i | input | 1 | 1 selects two stop bits |
| in_valid_i | input | 1 | Character available from the queue |
| in_data_i | input | 8 | Character |
| in_ready_o | output | 1 | Character accepted this cycle if valid |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
An accepted character shows up in the state one clock after the handshake, so the bench checks in_ready_o at the falling edge right after acceptance. The line and busy are registered and move one clock after a tick. The bench raises each tick for one cycle, starting at a falling edge, and samples the line at the next falling edge, after the tick has been registered. On the idle cycles between ticks it checks that the line has not moved. The tick that ends the last stop bit must drop busy in that same sampled cycle.

// File: rtl/serial_frame_tx_pkg.sv
package serial_frame_tx_pkg;
    localparam int DATA_W  = 8;
    localparam int MIN_LEN = 5;
    localparam int LEN_W   = $clog2(DATA_W - MIN_LEN + 1);
    localparam int IDX_W   = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_START, ST_DATA, ST_PAR, ST_STOP
    } tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [DATA_W-1:0]  shreg;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic               par_en;
        logic               par_bit;
        logic               two_stop;
        logic               tx;
        logic               busy;
    } tx_regs_t;
endpackage

// File: rtl/sft_len_decode.sv
module sft_len_decode
    import serial_frame_tx_pkg::*;
(
    input  logic [LEN_W-1:0] len_code_i,
    output logic [IDX_W-1:0] last_idx_o
);
    localparam int BASE = MIN_LEN - 1;
    always_comb begin
        last_idx_o = IDX_W'(BASE) + IDX_W'(len_code_i);
    end
endmodule

// File: rtl/sft_parity.sv
module sft_parity
    import serial_frame_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic              odd_i,
    output logic              par_o
);
    logic [DATA_W-1:0] kept;
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign kept[g] = data_i[g] & (IDX_W'(g) <= last_idx_i);
    end
    assign par_o = (^kept) ^ odd_i;
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import serial_frame_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tx_en_i,
    input  logic              bit_tick_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_two_stop_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              tx_o,
    output logic              busy_o
);
    tx_regs_t         r_d, r_q;
    logic [IDX_W-1:0] last_new;
    logic             par_new;

    sft_len_decode u_len (
        .len_code_i (cfg_len_i),
        .last_idx_o (last_new)
    );

    sft_parity u_par (
        .data_i     (in_data_i),
        .last_idx_i (last_new),
        .odd_i      (cfg_par_odd_i),
        .par_o      (par_new)
    );

    assign in_ready_o = (r_q.st == ST_IDLE) && en_i && tx_en_i;
    assign tx_o       = r_q.tx;
    assign busy_o     = r_q.busy;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.tx   = 1'b1;
                r_d.busy = 1'b0;
                if (in_valid_i && in_ready_o) begin
                    r_d.st       = ST_WAIT;
                    r_d.shreg    = in_data_i;
                    r_d.last     = last_new;
                    r_d.par_en   = cfg_par_en_i;
                    r_d.par_bit  = par_new;
                    r_d.two_stop = cfg_two_stop_i;
                end
            end
            ST_WAIT: begin
                if (bit_tick_i) begin
                    r_d.st   = ST_START;
                    r_d.tx   = 1'b0;
                    r_d.busy = 1'b1;
                end
            end
            ST_START: begin
                if (bit_tick_i) begin
                    r_d.st    = ST_DATA;
                    r_d.tx    = r_q.shreg[0];
                    r_d.shreg = r_q.shreg >> 1;
                    r_d.idx   = '0;
                end
            end
            ST_DATA: begin
                if (bit_tick_i) begin
                    if (r_q.idx == r_q.last) begin
                        if (r_q.par_en) begin
                            r_d.st = ST_PAR;
                            r_d.tx = r_q.par_bit;
                        end else begin
                            r_d.st = ST_STOP;
                            r_d.tx = 1'b1;
                        end
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.tx    = r_q.shreg[0];
                        r_d.shreg = r_q.shreg >> 1;
                    end
                end
            end
            ST_PAR: begin
                if (bit_tick_i) begin
                    r_d.st = ST_STOP;
                    r_d.tx = 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_tick_i) begin
                    if (r_q.two_stop) begin
                        r_d.two_stop = 1'b0;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                    end
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.tx   = 1'b1;
                r_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.tx       <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic tx_en_i,
    input logic bit_tick_i,
    input logic in_ready_o,
    input logic tx_o,
    input logic busy_o
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o) else $error("idle line low"); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tx_o) else $error("start bit not low"); // R2

    AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tx_o)) else $error("frame ended off stop"); // R5

    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick_i) |-> $stable(tx_o)) else $error("line moved without tick"); // R6

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !in_ready_o) else $error("ready during frame"); // R7

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (en_i && tx_en_i)) else $error("ready while disabled"); // R9

    AST_BUSY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick_i) |-> $stable(busy_o)) else $error("busy moved without tick"); // R8
endmodule

bind serial_frame_tx sft_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .tx_en_i    (tx_en_i),
    .bit_tick_i (bit_tick_i),
    .in_ready_o (in_ready_o),
    .tx_o       (tx_o),
    .busy_o     (busy_o)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b1, tx_en_i = 1'b1, bit_tick_i = 1'b0;
    logic [1:0] cfg_len_i = 2'd3;
    logic       cfg_par_en_i = 1'b0, cfg_par_odd_i = 1'b0, cfg_two_stop_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_ready_o, tx_o, busy_o;

    int n_chk = 0, n_err = 0;
    logic exp_bits [0:11];

    always #5 clk = ~clk;

    serial_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tx_en_i(tx_en_i),
        .bit_tick_i(bit_tick_i), .cfg_len_i(cfg_len_i),
        .cfg_par_en_i(cfg_par_en_i), .cfg_par_odd_i(cfg_par_odd_i),
        .cfg_two_stop_i(cfg_two_stop_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_ready_o(in_ready_o), .tx_o(tx_o),
        .busy_o(busy_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    function automatic int build(input logic [7:0] d, input int len, input logic pe,
                                 input logic po, input logic ts);
        int n = 0;
        logic p = po;
        exp_bits[n++] = 1'b0;
        for (int i = 0; i < len; i++) begin
            exp_bits[n++] = d[i];
            p ^= d[i];
        end
        if (pe) exp_bits[n++] = p;
        exp_bits[n++] = 1'b1;
        if (ts) exp_bits[n++] = 1'b1;
        return n;
    endfunction

    // one tick after gap idle cycles; line must hold during the gap (R6)
    task automatic tick_step(input int gap);
        logic prev = tx_o;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(tx_o == prev, "R6 hold", tx_o, prev);
        end
        bit_tick_i = 1'b1;
        @(negedge clk);
        bit_tick_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] lc, input logic pe,
                        input logic po, input logic ts, input int gap,
                        input int dis_at, input int chg_at);
        int n = build(d, int'(lc) + 5, pe, po, ts);
        int w = 0;
        cfg_len_i = lc; cfg_par_en_i = pe; cfg_par_odd_i = po; cfg_two_stop_i = ts;
        in_data_i = d; in_valid_i = 1'b1;
        while (!in_ready_o && w < 50) begin @(negedge clk); w++; end
        check(in_ready_o == 1'b1, "R7 ready when idle", in_ready_o, 1);
        @(posedge clk); @(negedge clk);
        in_valid_i = 1'b0;
        check(in_ready_o == 1'b0 && busy_o == 1'b0 && tx_o == 1'b1, "R7 accepted, waiting tick",
              {in_ready_o, busy_o, tx_o}, 3'b001);
        for (int k = 0; k < n; k++) begin
            tick_step(gap);
            check(tx_o == exp_bits[k], (k == 0) ? "R2 start bit" : "R3/R4/R5 frame bit",
                  tx_o, exp_bits[k]);
            check(busy_o == 1'b1 && in_ready_o == 1'b0, "R8 busy in frame", busy_o, 1);
            if (k == dis_at) begin en_i = 1'b0; in_valid_i = 1'b1; end
            if (k == chg_at) begin
                cfg_len_i = ~lc; cfg_par_en_i = ~pe; cfg_par_odd_i = ~po;
                cfg_two_stop_i = ~ts;
            end
        end
        tick_step(gap);
        check(busy_o == 1'b0 && tx_o == 1'b1, "R8 busy ends after last stop", busy_o, 0);
        check(in_ready_o == (en_i && tx_en_i), "R7 ready after frame", in_ready_o, en_i && tx_en_i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(tx_o == 1'b1 && busy_o == 1'b0, "R1 reset state", {tx_o, busy_o}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 1'b1, "R11 ready out of reset", in_ready_o, 1);

        send(8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 0, -1, -1);         // R3 8N1
        send(8'hE9, 2'd0, 1'b1, 1'b0, 1'b1, 2, -1, -1);         // R3 upper bits dropped, R4 even, R5 two stop
        send(8'h13, 2'd2, 1'b1, 1'b1, 1'b0, 1, -1, -1);         // R4 odd
        send(8'hA5, 2'd1, 1'b1, 1'b0, 1'b0, 3, -1, 4);          // R10 change mid-frame
        send(8'h3C, 2'd3, 1'b0, 1'b0, 1'b1, 1, 3, -1);          // R9 disable mid-frame

        // R9: while disabled, the pending character is ignored and the line stays high
        in_valid_i = 1'b1;
        for (int t = 0; t < 3; t++) begin
            tick_step(1);
            check(in_ready_o == 1'b0 && tx_o == 1'b1 && busy_o == 1'b0, "R9 held off while disabled",
                  {in_ready_o, tx_o, busy_o}, 3'b010);
        end
        en_i = 1'b1; tx_en_i = 1'b0;
        tick_step(0);
        check(in_ready_o == 1'b0 && tx_o == 1'b1, "R9 tx_en low blocks", in_ready_o, 0);
        tx_en_i = 1'b1;
        in_valid_i = 1'b0;
        @(negedge clk);
        check(in_ready_o == 1'b1, "R7 ready after re-enable", in_ready_o, 1);

        for (int r = 0; r < 40; r++) begin
            send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom % 4), -1, ($urandom % 3 == 0) ? 2 : -1);
        end
        finish_run();
    end
endmodule